// File: doc/BRIEF.md
# Address-Knock Partition Write Guard

This block sits between a memory controller's strobes and a RAM. It divides the RAM into sixteen equal regions, selected by the four most significant address lines, and can block write strobes aimed at any region whose protection bit is set. Every read cycle is a falling edge of the chip-enable strobe while the write strobe is high, and the address lines are sampled on that edge.

The protection map cannot be reached like an ordinary register. It loads only after twenty reads whose upper address nibbles form a fixed key, in exact order and with no write between them. The four reads that follow then supply the sixteen map bits, one nibble per read. Any write cycle sends the key matcher back to the start. A wrong nibble also restarts it, and that nibble is then tested as the first key step.

A mode input turns the whole function off. When it is off, the write output stays released and the address and write inputs have no effect. The mode level is frozen while the power-fail flag is raised, so the setting survives a supply dip.

Top module: `partition_write_guard`

## Requirements
- R1: After reset the protection map reads all zeros and the key matcher is at its first step.
- R2: The key is twenty reads whose nibble {z,y,x,w} (addr_hi[3:0], w = bit 0) takes the values F, E, 7, 7, 3, 9, C, E, 7, 3, 9, 4, 2, 4, A, 6, 9, 1, 0, 5 in that order. Only a full, uninterrupted match arms the load.
- R3: After a full match, the next four reads load map bits [3:0], [7:4], [11:8] and [15:12] in turn. Each read writes addr_hi bit i into bit 4k+i, where k counts from 0 for the first load read.
- R4: A write cycle (chip enable low with the write strobe low, block enabled) returns the matcher to the first step. Key reads made before it do not count.
- R5: A key read with the wrong nibble restarts the matcher. If that same nibble equals the first key value, it counts as step one.
- R6: While enabled, we_out_n equals we_in_n unless map bit addr_hi is 1, and in that case we_out_n stays high. we_out_n is never low while we_in_n is high.
- R7: With part_en low (and no power fail), we_out_n stays high and reads or writes change neither the map nor the matcher.
- R8: While pwr_fail is high, the enable keeps the part_en level seen on the last clock with pwr_fail low. Once pwr_fail drops, it follows part_en again.
- R9: After the fourth load read the matcher returns to idle. Later reads leave the map unchanged until another full key and load complete.
- R10: A read counts once per falling edge of ce_in_n, however long ce_in_n stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are already synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_in_n | input | 1 | Chip-enable strobe from the controller, active low |
| we_in_n | input | 1 | Write strobe from the controller, active low |
| addr_hi | input | 4 | Upper four address lines, bit 0 = w ... bit 3 = z |
| part_en | input | 1 | Partitioning enable, high = active |
| pwr_fail | input | 1 | Supply out-of-tolerance flag, high = failing |
| we_out_n | output | 1 | Gated write strobe to the RAM, active low |
| prot_map | output | 16 | Protection map, bit n guards region n |

## Verification
A behavioural reference model is compared with the outputs on every clock. The stimulus includes a clean key followed by a load, and a key broken by a write and then finished, which must not load. It also includes a key that opens with a repeated first nibble, which only loads if the restart rule re-tests the offending read. A map with an uneven bit pattern is swept across all sixteen regions, so that a swapped nibble order or a reversed bit order shows up. Further cases cover the disabled mode, the enable being frozen across a power fail, extra reads after a load, and a chip enable held low over several clocks.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  localparam int ADDR_W     = 4;
  localparam int PARTS      = 1 << ADDR_W;
  localparam int KEY_LEN    = 20;
  localparam int LOAD_READS = PARTS / ADDR_W;
  localparam int STEP_W     = $clog2(KEY_LEN + LOAD_READS);
  localparam int IDX_W      = $clog2(LOAD_READS);

  typedef logic [ADDR_W-1:0] nib_t;
  typedef logic [STEP_W-1:0] step_t;
  typedef logic [IDX_W-1:0]  idx_t;

  // Key nibble in {z,y,x,w} form for a given step.
  function automatic nib_t key_at(input int idx);
    nib_t v;
    case (idx)
      0:  v = 4'hF;
      1:  v = 4'hE;
      2:  v = 4'h7;
      3:  v = 4'h7;
      4:  v = 4'h3;
      5:  v = 4'h9;
      6:  v = 4'hC;
      7:  v = 4'hE;
      8:  v = 4'h7;
      9:  v = 4'h3;
      10: v = 4'h9;
      11: v = 4'h4;
      12: v = 4'h2;
      13: v = 4'h4;
      14: v = 4'hA;
      15: v = 4'h6;
      16: v = 4'h9;
      17: v = 4'h1;
      18: v = 4'h0;
      default: v = 4'h5;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/pwg_strobe_decode.sv
module pwg_strobe_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_in_n,
  input  logic we_in_n,
  input  logic part_en,
  input  logic pwr_fail,
  output logic en_eff,
  output logic rd_evt,
  output logic wr_evt
);
  logic ce_q, ce_d;
  logic en_lat_q, en_lat_d;

  always_comb begin
    ce_d     = ce_in_n;
    en_lat_d = en_lat_q;
    if (!pwr_fail) en_lat_d = part_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q     <= 1'b1;
      en_lat_q <= 1'b0;
    end else begin
      ce_q     <= ce_d;
      en_lat_q <= en_lat_d;
    end
  end

  assign en_eff = pwr_fail ? en_lat_q : part_en;
  assign rd_evt = en_eff & ce_q & ~ce_in_n & we_in_n;
  assign wr_evt = en_eff & ~ce_in_n & ~we_in_n;
endmodule

// File: rtl/pwg_key_matcher.sv
module pwg_key_matcher
  import pwg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_evt,
  input  logic  wr_evt,
  input  nib_t  addr,
  output step_t step,
  output logic  load_en,
  output idx_t  load_idx
);
  localparam step_t KEY_END   = step_t'(KEY_LEN);
  localparam step_t LOAD_LAST = step_t'(KEY_LEN + LOAD_READS - 1);

  step_t step_q, step_d;
  logic  in_load;

  assign in_load = (step_q >= KEY_END);

  always_comb begin
    step_d = step_q;
    if (wr_evt) begin
      step_d = '0;
    end else if (rd_evt) begin
      if (!in_load) begin
        if (addr == key_at(int'(step_q)))
          step_d = step_q + step_t'(1);
        else if (addr == key_at(0))
          step_d = step_t'(1);
        else
          step_d = '0;
      end else if (step_q == LOAD_LAST) begin
        step_d = '0;
      end else begin
        step_d = step_q + step_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  assign step     = step_q;
  assign load_en  = rd_evt & ~wr_evt & in_load;
  assign load_idx = idx_t'(step_q - KEY_END);
endmodule

// File: rtl/pwg_region_map.sv
module pwg_region_map
  import pwg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  idx_t             load_idx,
  input  nib_t             addr,
  input  logic             en_eff,
  input  logic             we_in_n,
  output logic [PARTS-1:0] prot_map,
  output logic             we_out_n
);
  logic [PARTS-1:0] map_q;

  for (genvar g = 0; g < LOAD_READS; g++) begin : g_grp
    logic grp_ce;
    assign grp_ce = load_en && (load_idx == idx_t'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      map_q[g*ADDR_W +: ADDR_W] <= '0;
      else if (grp_ce) map_q[g*ADDR_W +: ADDR_W] <= addr;
    end
  end

  assign prot_map = map_q;
  assign we_out_n = ~en_eff | we_in_n | map_q[addr];
endmodule

// File: rtl/partition_write_guard.sv
module partition_write_guard
  import pwg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_in_n,
  input  logic             we_in_n,
  input  logic [ADDR_W-1:0] addr_hi,
  input  logic             part_en,
  input  logic             pwr_fail,
  output logic             we_out_n,
  output logic [PARTS-1:0] prot_map
);
  logic  en_eff, rd_evt, wr_evt, load_en;
  step_t step;
  idx_t  load_idx;

  pwg_strobe_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n), .we_in_n(we_in_n),
    .part_en(part_en), .pwr_fail(pwr_fail),
    .en_eff(en_eff), .rd_evt(rd_evt), .wr_evt(wr_evt)
  );

  pwg_key_matcher u_match (
    .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt), .wr_evt(wr_evt),
    .addr(addr_hi), .step(step), .load_en(load_en), .load_idx(load_idx)
  );

  pwg_region_map u_map (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
    .addr(addr_hi), .en_eff(en_eff), .we_in_n(we_in_n),
    .prot_map(prot_map), .we_out_n(we_out_n)
  );
endmodule

// File: rtl/pwg_checker.sv
module pwg_checker
  import pwg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ce_in_n,
  input logic             we_in_n,
  input logic             part_en,
  input logic             pwr_fail,
  input logic             we_out_n,
  input logic [PARTS-1:0] prot_map,
  input logic             rd_evt,
  input logic             wr_evt,
  input step_t            step
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (prot_map == '0));

  assert_step_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step <= step_t'(KEY_LEN + LOAD_READS - 1));

  assert_map_only_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_map) |-> $past(rd_evt && (step >= step_t'(KEY_LEN))));

  assert_write_resets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> (step == '0));

  assert_no_spurious_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we_in_n |-> we_out_n);

  assert_disabled_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!part_en && !pwr_fail) |-> (we_out_n && !rd_evt && !wr_evt));
endmodule

bind partition_write_guard pwg_checker u_pwg_chk (
  .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n), .we_in_n(we_in_n),
  .part_en(part_en), .pwr_fail(pwr_fail), .we_out_n(we_out_n),
  .prot_map(prot_map), .rd_evt(rd_evt), .wr_evt(wr_evt), .step(step)
);

// File: tb/test_partition_write_guard.sv
`timescale 1ns/1ps
module test_partition_write_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_in_n = 1'b1;
  logic we_in_n = 1'b1;
  logic [3:0] addr_hi = 4'h0;
  logic part_en = 1'b1;
  logic pwr_fail = 1'b0;
  logic we_out_n;
  logic [15:0] prot_map;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // Key written in (w,x,y,z) order, MSB = w.
  logic [3:0] key_wxyz [20] = '{4'b1111, 4'b0111, 4'b1110, 4'b1110, 4'b1100,
                                4'b1001, 4'b0011, 4'b0111, 4'b1110, 4'b1100,
                                4'b1001, 4'b0010, 4'b0100, 4'b0010, 4'b0101,
                                4'b0110, 4'b1001, 4'b1000, 4'b0000, 4'b1010};

  // Reference model state
  int m_cnt = 0;
  logic [15:0] m_map = '0;
  logic m_prev_ce = 1'b1;
  logic m_lat = 1'b0;

  always #4 clk = ~clk;

  partition_write_guard i_partition_write_guard (
    .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n), .we_in_n(we_in_n),
    .addr_hi(addr_hi), .part_en(part_en), .pwr_fail(pwr_fail),
    .we_out_n(we_out_n), .prot_map(prot_map)
  );

  function automatic logic [3:0] key_addr(input int i);
    logic [3:0] b;
    b = key_wxyz[i];
    return {b[0], b[1], b[2], b[3]};
  endfunction

  always @(posedge clk) begin
    logic en_m, rd, wr;
    if (!rst_n) begin
      m_cnt = 0; m_map = '0; m_prev_ce = 1'b1; m_lat = 1'b0;
    end else begin
      en_m = pwr_fail ? m_lat : part_en;
      rd = en_m && m_prev_ce && !ce_in_n && we_in_n;
      wr = en_m && !ce_in_n && !we_in_n;
      if (wr) m_cnt = 0;
      else if (rd) begin
        if (m_cnt < 20) begin
          if (addr_hi == key_addr(m_cnt)) m_cnt++;
          else m_cnt = (addr_hi == key_addr(0)) ? 1 : 0;
        end else begin
          for (int i = 0; i < 4; i++) m_map[4*(m_cnt-20)+i] = addr_hi[i];
          m_cnt = (m_cnt == 23) ? 0 : m_cnt + 1;
        end
      end
      if (!pwr_fail) m_lat = part_en;
      m_prev_ce = ce_in_n;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Compare every clock, 3 ns after the rising edge.
  always @(posedge clk) begin
    logic en_now, exp_we;
    #3;
    if (rst_n && !done) begin
      en_now = pwr_fail ? m_lat : part_en;
      exp_we = !en_now || we_in_n || m_map[addr_hi];
      check(cur_req, "prot_map", {16'h0, prot_map}, {16'h0, m_map});
      check(cur_req, "we_out_n", {31'h0, we_out_n}, {31'h0, exp_we});
    end
  end

  task automatic rd_cycle(input logic [3:0] a, input int hold = 1);
    @(negedge clk); ce_in_n = 1'b0; we_in_n = 1'b1; addr_hi = a;
    repeat (hold) @(negedge clk);
    ce_in_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_cycle(input logic [3:0] a);
    @(negedge clk); ce_in_n = 1'b0; addr_hi = a; we_in_n = 1'b0;
    @(negedge clk); we_in_n = 1'b1; ce_in_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_key(input int upto = 20);
    for (int i = 0; i < upto; i++) rd_cycle(key_addr(i));
  endtask

  task automatic send_map(input logic [15:0] v);
    for (int k = 0; k < 4; k++) rd_cycle(v[4*k +: 4]);
  endtask

  // Write strobe held inside the region; checked while strobe is low.
  task automatic probe_region(input logic [3:0] a, input logic exp_n, input string req);
    @(negedge clk); ce_in_n = 1'b0; addr_hi = a; we_in_n = 1'b0;
    #1 check(req, "we_out_n probe", {31'h0, we_out_n}, {31'h0, exp_n});
    @(negedge clk); we_in_n = 1'b1; ce_in_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    check("R1", "map after reset", {16'h0, prot_map}, 32'h0);

    cur_req = "R2";
    send_key(); send_map(16'hA53C);
    check("R2", "map after clean key", {16'h0, prot_map}, 32'hA53C);
    check("R3", "nibble order", {16'h0, prot_map}, 32'hA53C);

    cur_req = "R6";
    for (int r = 0; r < 16; r++) probe_region(4'(r), 1'(16'hA53C >> r), "R6");

    cur_req = "R9";
    send_map(16'hFFFF);
    check("R9", "map kept after load", {16'h0, prot_map}, 32'hA53C);

    cur_req = "R4";
    send_key(12); wr_cycle(4'h0); send_key(20); send_map(16'h0F0F);
    check("R4", "write mid key then reload", {16'h0, prot_map}, 32'h0F0F);
    send_key(15); wr_cycle(4'h3);
    for (int i = 15; i < 20; i++) rd_cycle(key_addr(i));
    send_map(16'h1234);
    check("R4", "broken key does not load", {16'h0, prot_map}, 32'h0F0F);

    cur_req = "R5";
    rd_cycle(key_addr(0)); send_key(); send_map(16'h8001);
    check("R5", "restart re-tests read", {16'h0, prot_map}, 32'h8001);
    rd_cycle(4'h6); send_key(); send_map(16'h4002);
    check("R5", "junk then key", {16'h0, prot_map}, 32'h4002);

    cur_req = "R10";
    for (int i = 0; i < 20; i++) rd_cycle(key_addr(i), (i == 7) ? 4 : 1);
    send_map(16'h00F1);
    check("R10", "long ce counted once", {16'h0, prot_map}, 32'h00F1);

    cur_req = "R7";
    part_en = 1'b0;
    send_key(); send_map(16'hFFFF);
    probe_region(4'h0, 1'b1, "R7");
    probe_region(4'h1, 1'b1, "R7");
    check("R7", "map unchanged when off", {16'h0, prot_map}, 32'h00F1);
    part_en = 1'b1;
    send_map(16'hFFFF);
    check("R7", "no armed matcher when off", {16'h0, prot_map}, 32'h00F1);

    cur_req = "R8";
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk); part_en = 1'b0;
    probe_region(4'h0, 1'b1, "R8");
    probe_region(4'h1, 1'b0, "R8");
    @(negedge clk); pwr_fail = 1'b0;
    probe_region(4'h1, 1'b1, "R8");
    @(negedge clk); part_en = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule